// File: doc/BRIEF.md
# Shift-Chain Row Programmer for a Configuration Memory Array

This block writes a two-dimensional configuration memory, one row at a time. Each cell sits where one bit-line crosses one word-line.

Two serial shift chains drive the array:
- The bit-line chain holds the data for one row.
- The word-line chain holds a one-hot pattern that picks the target row.

Each chain has its own shift enable and can be loaded on its own. A counter beside each chain records how many shifts it has taken. Once both counters show a full chain, a program strobe copies every bit-line value into the cells of the selected row in one clock. Both counters then clear, ready for the next row. A strobe that arrives too early, or with a word-line pattern that is not one-hot, writes nothing and raises an error pulse.

Either chain may be cut into several banks that shift in parallel. Each bank has its own serial input. The parameter that sets the bank count defaults to one. Bank lengths differ by at most one, so a full load takes as many shifts as the longest bank. One instance serves one configuration region. Separate regions use separate instances and never share a word-line. The array is modelled as flip-flops with bit-line/word-line write behaviour.

Top module: `blwl_row_programmer`

## Requirements
- R1: While reset is asserted and just after it is released, all cell outputs are 0, both full flags are 0, and the done and error pulses are 0.
- R2: A chain of N lines split into B banks gives bank b a length of floor(N/B), plus 1 when b < N mod B. The banks sit in order from line index 0 upward. On each shift, bank b takes its serial input bit b into its highest line and moves its other bits one place toward its lowest line. After L shifts, the first bit of those L sits on the bank's lowest line.
- R3: The bit-line full flag rises once the bit-line chain has taken ceil(COLS/B) shifts since it was last cleared. Further shifts keep moving data through the chain and leave the flag high.
- R4: The word-line full flag follows the same rule, with ceil(ROWS/B) shifts.
- R5: A strobe accepted with both chains full and a one-hot word-line pattern copies the bit-line chain into the selected row. Bit-line c goes to cell (r, c), which is output bit r*COLS+c. All other rows are left as they were. The done output pulses for one cycle after the strobe.
- R6: A strobe while either chain is not full writes no cell. The error output pulses one cycle later, and both shift counters keep their values.
- R7: A strobe with both chains full but an all-zero or multi-hot word-line pattern writes no cell and pulses the error output.
- R8: After an accepted strobe, both full flags are low on the next cycle, and each chain needs a complete reload.
- R9: In any cycle where the strobe is high, both shift enables are ignored: no data moves and no counter advances.
- R10: Done and error are single-cycle pulses, registered one cycle after the strobe, and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bl_shift_en | input | 1 | Shift the bit-line chain this cycle |
| bl_din | input | NBANK | Serial input of each bit-line bank |
| wl_shift_en | input | 1 | Shift the word-line chain this cycle |
| wl_din | input | NBANK | Serial input of each word-line bank |
| prog_strobe | input | 1 | Request a row write |
| bl_full | output | 1 | Bit-line chain fully loaded |
| wl_full | output | 1 | Word-line chain fully loaded |
| prog_done | output | 1 | Pulse: the previous strobe wrote a row |
| prog_err | output | 1 | Pulse: the previous strobe was rejected |
| cfg_bits | output | ROWS*COLS | Cell contents, row r at bits r*COLS upward |

## Verification
The full flags are combinational from the counters, so they change right after the clock edge that takes the last needed shift. The bench reads them at the falling edge after that shift. A strobe changes the cells, the done and error pulses, and the cleared full flags all at the same edge. The bench therefore samples all of them at the falling edge that follows the strobe cycle, and checks one cycle later that the pulses have fallen. Inputs change only on falling edges, so each rising edge sees one settled stimulus.

// File: rtl/blwl_pkg.sv
package blwl_pkg;

  // Length of bank b when total lines are spread over nb banks.
  function automatic int bank_len(input int total, input int nb, input int b);
    return (total / nb) + ((b < (total % nb)) ? 1 : 0);
  endfunction

  // Lowest line index that bank b drives.
  function automatic int bank_off(input int total, input int nb, input int b);
    return b * (total / nb) + ((b < (total % nb)) ? b : (total % nb));
  endfunction

  // Shifts needed to fill the longest bank.
  function automatic int chain_fill(input int total, input int nb);
    return (total + nb - 1) / nb;
  endfunction

endpackage

// File: rtl/blwl_shift_chain.sv
module blwl_shift_chain
  import blwl_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NBANK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_go,
  input  logic [NBANK-1:0] din,
  output logic [WIDTH-1:0] lines
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LEN = bank_len(WIDTH, NBANK, b);
    localparam int OFF = bank_off(WIDTH, NBANK, b);

    logic [LEN-1:0] seg_q;
    logic [LEN-1:0] seg_d;

    if (LEN == 1) begin : g_single
      always_comb begin
        seg_d = seg_q;
        if (shift_go) seg_d = din[b];
      end
    end else begin : g_multi
      always_comb begin
        seg_d = seg_q;
        if (shift_go) seg_d = {din[b], seg_q[LEN-1:1]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q <= '0;
      else        seg_q <= seg_d;
    end

    assign lines[OFF +: LEN] = seg_q;
  end

endmodule

// File: rtl/blwl_prog_ctrl.sv
module blwl_prog_ctrl #(
  parameter int ROWS    = 8,
  parameter int BL_FILL = 8,
  parameter int WL_FILL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bl_go,
  input  logic            wl_go,
  input  logic            strobe,
  input  logic [ROWS-1:0] wl_vec,
  output logic            wr_en,
  output logic            bl_full,
  output logic            wl_full,
  output logic            done,
  output logic            err
);

  localparam int BCW = $clog2(BL_FILL + 1);
  localparam int WCW = $clog2(WL_FILL + 1);

  logic [BCW-1:0] bl_cnt_q, bl_cnt_d;
  logic [WCW-1:0] wl_cnt_q, wl_cnt_d;
  logic           done_d, err_d;
  logic           wl_single;

  assign bl_full   = (bl_cnt_q == BCW'(BL_FILL));
  assign wl_full   = (wl_cnt_q == WCW'(WL_FILL));
  assign wl_single = (wl_vec != '0) && ((wl_vec & (wl_vec - ROWS'(1))) == '0);
  assign wr_en     = strobe && bl_full && wl_full && wl_single;

  always_comb begin
    bl_cnt_d = bl_cnt_q;
    wl_cnt_d = wl_cnt_q;
    if (wr_en) begin
      bl_cnt_d = '0;
      wl_cnt_d = '0;
    end else begin
      if (bl_go && !bl_full) bl_cnt_d = bl_cnt_q + BCW'(1);
      if (wl_go && !wl_full) wl_cnt_d = wl_cnt_q + WCW'(1);
    end
    done_d = wr_en;
    err_d  = strobe && !wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_cnt_q <= '0;
      wl_cnt_q <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      bl_cnt_q <= bl_cnt_d;
      wl_cnt_q <= wl_cnt_d;
      done     <= done_d;
      err      <= err_d;
    end
  end

endmodule

// File: rtl/blwl_cell_array.sv
module blwl_cell_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ROWS-1:0]      wl,
  input  logic [COLS-1:0]      bl,
  output logic [ROWS*COLS-1:0] cells
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    logic [COLS-1:0] row_d;

    always_comb begin
      row_d = row_q;
      if (wr_en && wl[r]) row_d = bl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_d;
    end

    assign cells[r*COLS +: COLS] = row_q;
  end

endmodule

// File: rtl/blwl_row_programmer.sv
module blwl_row_programmer
  import blwl_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int NBANK = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bl_shift_en,
  input  logic [NBANK-1:0]     bl_din,
  input  logic                 wl_shift_en,
  input  logic [NBANK-1:0]     wl_din,
  input  logic                 prog_strobe,
  output logic                 bl_full,
  output logic                 wl_full,
  output logic                 prog_done,
  output logic                 prog_err,
  output logic [ROWS*COLS-1:0] cfg_bits
);

  localparam int BL_FILL = chain_fill(COLS, NBANK);
  localparam int WL_FILL = chain_fill(ROWS, NBANK);

  logic            bl_go, wl_go, wr_en;
  logic [COLS-1:0] bl_vec;
  logic [ROWS-1:0] wl_vec;

  assign bl_go = bl_shift_en && !prog_strobe;
  assign wl_go = wl_shift_en && !prog_strobe;

  blwl_shift_chain #(.WIDTH(COLS), .NBANK(NBANK)) u_bl_chain (
    .clk(clk), .rst_n(rst_n), .shift_go(bl_go), .din(bl_din), .lines(bl_vec)
  );

  blwl_shift_chain #(.WIDTH(ROWS), .NBANK(NBANK)) u_wl_chain (
    .clk(clk), .rst_n(rst_n), .shift_go(wl_go), .din(wl_din), .lines(wl_vec)
  );

  blwl_prog_ctrl #(.ROWS(ROWS), .BL_FILL(BL_FILL), .WL_FILL(WL_FILL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bl_go(bl_go), .wl_go(wl_go),
    .strobe(prog_strobe), .wl_vec(wl_vec), .wr_en(wr_en),
    .bl_full(bl_full), .wl_full(wl_full), .done(prog_done), .err(prog_err)
  );

  blwl_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wl(wl_vec), .bl(bl_vec),
    .cells(cfg_bits)
  );

endmodule

module blwl_row_programmer_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 prog_strobe,
  input logic                 bl_full,
  input logic                 wl_full,
  input logic                 prog_done,
  input logic                 prog_err,
  input logic [ROWS-1:0]      wl_vec,
  input logic [ROWS*COLS-1:0] cfg_bits
);

  // R6
  early_strobe_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe && !(bl_full && wl_full)) |=> prog_err);

  // R6
  early_strobe_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe && !(bl_full && wl_full)) |=> $stable(cfg_bits));

  // R7
  bad_select_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe && !$onehot(wl_vec)) |=> (prog_err && !prog_done && $stable(cfg_bits)));

  // R8
  write_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe && bl_full && wl_full && $onehot(wl_vec)) |=> (prog_done && !bl_full && !wl_full));

  // R9
  strobe_freezes_bl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe && !bl_full) |=> !bl_full);

  // R9
  strobe_freezes_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_strobe && !wl_full) |=> !wl_full);

  // R3
  bl_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_full && !prog_strobe) |=> bl_full);

  // R10
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_done && prog_err));

  // R10
  no_strobe_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_strobe |=> (!prog_done && !prog_err));

endmodule

bind blwl_row_programmer blwl_row_programmer_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_strobe(prog_strobe), .bl_full(bl_full),
  .wl_full(wl_full), .prog_done(prog_done), .prog_err(prog_err),
  .wl_vec(wl_vec), .cfg_bits(cfg_bits)
);

// File: tb/blwl_row_programmer_tb_top.sv
module blwl_row_programmer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 7;
  localparam int COLS  = 10;
  localparam int NBANK = 3;
  localparam int NV    = 6;

  // entry: {bit-line pattern, word-line pattern, expect write}
  localparam logic [COLS+ROWS:0] VEC [NV] = '{
    {10'h2A5, 7'b0000001, 1'b1},
    {10'h35C, 7'b1000000, 1'b1},
    {10'h0F0, 7'b0001000, 1'b1},
    {10'h3FF, 7'b0000000, 1'b0},
    {10'h155, 7'b0010010, 1'b0},
    {10'h00F, 7'b0001000, 1'b1}
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 bl_shift_en, wl_shift_en, prog_strobe;
  logic [NBANK-1:0]     bl_din, wl_din;
  logic                 bl_full, wl_full, prog_done, prog_err;
  logic [ROWS*COLS-1:0] cfg_bits;
  logic [ROWS*COLS-1:0] exp_cfg;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blwl_row_programmer #(.ROWS(ROWS), .COLS(COLS), .NBANK(NBANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bl_shift_en(bl_shift_en), .bl_din(bl_din),
    .wl_shift_en(wl_shift_en), .wl_din(wl_din), .prog_strobe(prog_strobe),
    .bl_full(bl_full), .wl_full(wl_full), .prog_done(prog_done),
    .prog_err(prog_err), .cfg_bits(cfg_bits)
  );

  function automatic int blen(int n, int b);
    return n / NBANK + ((b < n % NBANK) ? 1 : 0);
  endfunction

  function automatic int boff(int n, int b);
    int o = 0;
    for (int i = 0; i < b; i++) o += blen(n, i);
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: one full load of the bit-line chain; filler 1s fall off short banks
  task automatic load_bl(input logic [COLS-1:0] pat);
    int fill = (COLS + NBANK - 1) / NBANK;
    for (int k = 0; k < fill; k++) begin
      for (int b = 0; b < NBANK; b++) begin
        int drop = fill - blen(COLS, b);
        bl_din[b] = (k >= drop) ? pat[boff(COLS, b) + k - drop] : 1'b1;
      end
      bl_shift_en = 1'b1;
      @(negedge clk);
    end
    bl_shift_en = 1'b0;
  endtask

  task automatic load_wl(input logic [ROWS-1:0] pat);
    int fill = (ROWS + NBANK - 1) / NBANK;
    for (int k = 0; k < fill; k++) begin
      for (int b = 0; b < NBANK; b++) begin
        int drop = fill - blen(ROWS, b);
        wl_din[b] = (k >= drop) ? pat[boff(ROWS, b) + k - drop] : 1'b1;
      end
      wl_shift_en = 1'b1;
      @(negedge clk);
    end
    wl_shift_en = 1'b0;
  endtask

  task automatic strobe_once();
    prog_strobe = 1'b1;
    @(negedge clk);
    prog_strobe = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    bl_shift_en = 1'b0; wl_shift_en = 1'b0; prog_strobe = 1'b0;
    bl_din = '0; wl_din = '0;
    exp_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cfg_bits == '0, "R1 cells", cfg_bits, 0);
    chk({bl_full, wl_full, prog_done, prog_err} == 4'b0, "R1 flags",
        {bl_full, wl_full, prog_done, prog_err}, 0);

    // R3: three of four shifts leave the chain not full
    bl_din = '1;
    bl_shift_en = 1'b1;
    repeat (3) @(negedge clk);
    bl_shift_en = 1'b0;
    chk(!bl_full, "R3 partial", bl_full, 0);

    // R3: four further shifts (seven in all) give full; the last four count
    load_bl(10'h1C3);
    chk(bl_full, "R3 full after extra shifts", bl_full, 1);

    // R6: strobe with word-line chain empty
    strobe_once();
    chk(prog_err && !prog_done, "R6 err pulse", {prog_done, prog_err}, 2'b01);
    chk(cfg_bits == exp_cfg, "R6 no write", cfg_bits, exp_cfg);
    chk(bl_full, "R6 counter kept", bl_full, 1);

    // R4: two of three word-line shifts
    wl_din = '0;
    wl_shift_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wl_full, "R4 partial", wl_full, 0);

    // R9: shift requested in the strobe cycle is ignored
    prog_strobe = 1'b1;
    @(negedge clk);
    prog_strobe = 1'b0;
    wl_shift_en = 1'b0;
    chk(prog_err, "R9 strobe rejected", prog_err, 1);
    chk(!wl_full, "R9 shift ignored", wl_full, 0);

    // R10: pulse lasts one cycle
    @(negedge clk);
    chk(!prog_err && !prog_done, "R10 pulse ends", {prog_done, prog_err}, 0);

    // R4 / R5 / R8: select row 5 and write
    load_wl(7'b0100000);
    chk(wl_full, "R4 full", wl_full, 1);
    strobe_once();
    exp_cfg[5*COLS +: COLS] = 10'h1C3;
    chk(prog_done && !prog_err, "R5 done pulse", {prog_done, prog_err}, 2'b10);
    chk(cfg_bits == exp_cfg, "R5 R2 row 5 data", cfg_bits, exp_cfg);
    chk(!bl_full && !wl_full, "R8 flags cleared", {bl_full, wl_full}, 0);

    // table of rows, selects and expected results
    for (int i = 0; i < NV; i++) begin
      logic [COLS-1:0] bp;
      logic [ROWS-1:0] wp;
      logic            ok;
      {bp, wp, ok} = VEC[i];
      load_bl(bp);
      load_wl(wp);
      strobe_once();
      if (ok) begin
        for (int r = 0; r < ROWS; r++)
          if (wp[r]) exp_cfg[r*COLS +: COLS] = bp;
        chk(prog_done && !prog_err, "R5 vector pulse", {prog_done, prog_err}, 2'b10);
        chk(!bl_full && !wl_full, "R8 vector flags", {bl_full, wl_full}, 0);
      end else begin
        chk(prog_err && !prog_done, "R7 vector pulse", {prog_done, prog_err}, 2'b01);
        chk(bl_full && wl_full, "R7 counters kept", {bl_full, wl_full}, 2'b11);
      end
      chk(cfg_bits == exp_cfg, "R5 R7 vector cells", cfg_bits, exp_cfg);
    end

    @(negedge clk);
    chk(!prog_err && !prog_done, "R10 idle", {prog_done, prog_err}, 0);

    finish_run();
  end

endmodule